// File: doc/BRIEF.md
# Transmit FIFO serializer with done flag

This block sits between a host that produces bytes and a modulator that needs one bit per bit period. The host writes bytes into a byte FIFO whose usable capacity is picked at run time from four sizes. A shift register takes bytes from the FIFO and sends them out most significant bit first, one bit on each bit-rate strobe. Bytes follow one another with no gap between them.

The block reports FIFO-full and FIFO-empty status. It gives a one-clock data-clock pulse for every bit it puts out and a one-clock transmit-start pulse when a transmission begins. It also raises a sticky overflow flag for writes that were refused. The transmit-done flag is meant for the host's interrupt logic. It rises only once the FIFO is empty and the last bit has been held on the serial output for a full bit period. An empty FIFO on its own does not raise it. This lets the host switch the radio off without cutting the final bit short.

Top module: `txs_serializer`

## Requirements
- R1: After a synchronous reset, `ser_out`, `data_clk`, `tx_start`, `tx_done`, `fifo_full` and `overflow` are 0 and `fifo_empty` is 1.
- R2: `cap_sel` sets the FIFO capacity: 2'b00 gives 16 bytes, 2'b01 gives 32, 2'b10 gives 48 and 2'b11 gives 64. The byte held in the shift register does not count toward this. `fifo_full` is 1 while the stored count is at or above the capacity, and `fifo_empty` is 1 while the count is zero.
- R3: A write made while `fifo_full` is 1 stores nothing, so that byte never appears on the serial output. It also sets `overflow`, which stays at 1 until reset.
- R4: While the shift register is idle and the FIFO holds a byte, the shift register loads that byte on the next clock edge without waiting for a strobe. `tx_start` is then high for exactly one clock. Bytes reloaded during a running transmission do not pulse `tx_start`.
- R5: On each `bit_stb` cycle of an active transmission, `ser_out` takes the next bit, most significant bit first. It holds that value until the next strobe.
- R6: `data_clk` is high for exactly one clock after each strobe edge that puts a bit on `ser_out`, and is low at all other times.
- R7: At the strobe that follows a byte's eighth bit, the first bit of the next byte goes out if the FIFO is not empty, so there is no idle bit period between bytes.
- R8: If the FIFO is empty at the strobe that follows the last byte's eighth bit, `tx_done` goes to 1, `ser_out` returns to 0, and the shifter becomes idle.
- R9: `tx_done` returns to 0 at the clock edge that accepts a write into the FIFO.
- R10: Strobes while idle have no effect: `ser_out` stays 0, `data_clk` stays 0 and `tx_done` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_sel | input | 2 | FIFO capacity select: 16, 32, 48 or 64 bytes |
| wr_en | input | 1 | Write strobe for one byte |
| wr_byte | input | 8 | Byte to write |
| bit_stb | input | 1 | Bit-rate strobe, one clock wide |
| ser_out | output | 1 | Serial data to the modulator, MSB first |
| data_clk | output | 1 | One-clock pulse for each bit put out |
| tx_start | output | 1 | One-clock pulse when a transmission starts |
| tx_done | output | 1 | FIFO drained and last bit fully sent |
| fifo_full | output | 1 | Stored count has reached the capacity |
| fifo_empty | output | 1 | FIFO holds no bytes |
| overflow | output | 1 | Sticky: a write was refused while full |

## Verification
Each result has a fixed delay after its stimulus:
- A write shows on `fifo_empty`, `fifo_full`, `overflow` and `tx_done` one edge later.
- An idle load empties a one-byte FIFO and raises `tx_start` at the following edge, which is the second edge after the write.
- A strobe shows on `ser_out` and `data_clk` at that same edge.
- `tx_done` rises at the ninth strobe edge after the last byte was loaded.

The bench changes inputs 2 ns after a rising edge and samples 2 ns after the next one. Every check therefore reads the value due at the edge just passed. The gap cycles between strobes check that `data_clk` is low and that `ser_out` holds its value. The capacity tests count writes exactly, including the byte taken at once by the shifter, so that `fifo_full` is checked one write before and one write after the limit.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int unsigned BYTE_W = 8;

  // capacity in bytes for a 2-bit select: (sel + 1) slices
  function automatic int unsigned cap_bytes(input logic [1:0] sel, input int unsigned slice);
    return ({30'd0, sel} + 32'd1) * slice;
  endfunction
endpackage

// File: rtl/txs_fifo.sv
module txs_fifo #(
  parameter int unsigned SLICE = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cap_sel,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic          overflow
);
  localparam int unsigned DEPTH = 4 * SLICE;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cap;
  logic          ovf_q;
  logic          accept, take;

  always_comb begin
    cap    = CW'(txs_pkg::cap_bytes(cap_sel, SLICE));
    full   = (cnt_q >= cap);
    empty  = (cnt_q == '0);
    accept = push && !full;
    take   = pop && !empty;
  end

  // storage: no reset, single write port
  always_ff @(posedge clk) begin
    if (accept) mem[wp_q] <= push_data;
  end

  assign head = mem[rp_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (accept) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (take)   rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      case ({accept, take})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (push && full) ovf_q <= 1'b1;
    end
  end

  assign overflow = ovf_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  assert_no_pop_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  input  logic          wr_seen,
  output logic          src_take,
  output logic          ser_out,
  output logic          data_clk,
  output logic          tx_start,
  output logic          tx_done
);
  localparam int unsigned CNTW = $clog2(DW + 1);

  logic            busy_q;
  logic [DW-1:0]   sreg_q;
  logic [CNTW-1:0] nbit_q;
  logic            ser_q, dclk_q, start_q, done_q;
  logic            all_out;

  assign all_out  = (nbit_q == CNTW'(DW));
  assign src_take = src_valid && (!busy_q || (bit_stb && all_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      sreg_q  <= '0;
      nbit_q  <= '0;
      ser_q   <= 1'b0;
      dclk_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      dclk_q  <= 1'b0;
      start_q <= 1'b0;
      if (!busy_q) begin
        if (src_valid) begin
          sreg_q  <= src_data;
          nbit_q  <= '0;
          busy_q  <= 1'b1;
          start_q <= 1'b1;
        end
      end else if (bit_stb) begin
        if (!all_out) begin
          ser_q  <= sreg_q[DW-1];
          sreg_q <= {sreg_q[DW-2:0], 1'b0};
          nbit_q <= nbit_q + CNTW'(1);
          dclk_q <= 1'b1;
        end else if (src_valid) begin
          ser_q  <= src_data[DW-1];
          sreg_q <= {src_data[DW-2:0], 1'b0};
          nbit_q <= CNTW'(1);
          dclk_q <= 1'b1;
        end else begin
          ser_q  <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (wr_seen) done_q <= 1'b0;
    end
  end

  assign ser_out  = ser_q;
  assign data_clk = dclk_q;
  assign tx_start = start_q;
  assign tx_done  = done_q;

  assert_start_one_clock_R4: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  assert_start_means_busy_R4: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy_q);
  assert_dclk_follows_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    dclk_q |-> $past(bit_stb));
  assert_idle_line_low_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !ser_q);
  assert_done_only_drained_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (!busy_q && !src_valid));
endmodule

// File: rtl/txs_serializer.sv
module txs_serializer #(
  parameter int unsigned SLICE_BYTES = 16,
  parameter int unsigned DATA_W      = txs_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cap_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              bit_stb,
  output logic              ser_out,
  output logic              data_clk,
  output logic              tx_start,
  output logic              tx_done,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              overflow
);
  logic [DATA_W-1:0] head;
  logic              take;
  logic              wr_ok;

  assign wr_ok = wr_en && !fifo_full;

  txs_fifo #(.SLICE(SLICE_BYTES), .DW(DATA_W)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .cap_sel   (cap_sel),
    .push      (wr_en),
    .push_data (wr_byte),
    .pop       (take),
    .head      (head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .overflow  (overflow)
  );

  txs_shifter #(.DW(DATA_W)) shift_i (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .src_valid (!fifo_empty),
    .src_data  (head),
    .wr_seen   (wr_ok),
    .src_take  (take),
    .ser_out   (ser_out),
    .data_clk  (data_clk),
    .tx_start  (tx_start),
    .tx_done   (tx_done)
  );

  assert_done_clears_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> !tx_done);
  assert_idle_strobe_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && !ser_out && tx_done && bit_stb) |=> !data_clk);
endmodule

// File: tb/txs_serializer_tb_top.sv
module txs_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cap_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       bit_stb = 1'b0;
  logic ser_out, data_clk, tx_start, tx_done, fifo_full, fifo_empty, overflow;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_b [0:127];

  always #10 clk = ~clk;

  txs_serializer dut_i (
    .clk(clk), .rst(rst), .cap_sel(cap_sel), .wr_en(wr_en), .wr_byte(wr_byte),
    .bit_stb(bit_stb), .ser_out(ser_out), .data_clk(data_clk), .tx_start(tx_start),
    .tx_done(tx_done), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; bit_stb = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic push_byte(input logic [7:0] b);
    wr_en = 1'b1; wr_byte = b;
    step();
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    bit_stb = 1'b1;
    step();
    bit_stb = 1'b0;
  endtask

  // send n bytes from exp_b, gap idle cycles between strobes, then the done strobe
  task automatic run_bytes(input int n, input int gap, input string tag);
    int starts = 0;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        strobe();
        chk({tag, " R5 bit"}, int'(ser_out), int'(exp_b[i][b]));
        chk({tag, " R6 data_clk"}, int'(data_clk), 1);
        chk({tag, " R8 done low"}, int'(tx_done), 0);
        if (tx_start) starts++;
        for (int g = 0; g < gap; g++) begin
          step();
          chk({tag, " R6 data_clk gap"}, int'(data_clk), 0);
          chk({tag, " R5 hold"}, int'(ser_out), int'(exp_b[i][b]));
          if (tx_start) starts++;
        end
      end
    end
    chk({tag, " R4 no restart"}, starts, 0);
    strobe();
    chk({tag, " R8 done"}, int'(tx_done), 1);
    chk({tag, " R8 line low"}, int'(ser_out), 0);
    chk({tag, " R6 no data_clk"}, int'(data_clk), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ser_out", int'(ser_out), 0);
    chk("R1 data_clk", int'(data_clk), 0);
    chk("R1 tx_start", int'(tx_start), 0);
    chk("R1 tx_done", int'(tx_done), 0);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 overflow", int'(overflow), 0);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 3; k++) begin
      strobe();
      chk("R10 idle ser_out", int'(ser_out), 0);
      chk("R10 idle data_clk", int'(data_clk), 0);
      chk("R10 idle done", int'(tx_done), 0);
    end
  endtask

  task automatic t_single();
    push_byte(8'hA5);
    chk("R2 not empty", int'(fifo_empty), 0);
    chk("R4 no early start", int'(tx_start), 0);
    step();
    chk("R4 start pulse", int'(tx_start), 1);
    chk("R4 loaded", int'(fifo_empty), 1);
    step();
    chk("R4 start one clock", int'(tx_start), 0);
    chk("R5 line low before strobe", int'(ser_out), 0);
    exp_b[0] = 8'hA5;
    run_bytes(1, 2, "single");
    // done persists through idle strobes
    strobe();
    chk("R10 done kept", int'(tx_done), 1);
    chk("R10 data_clk quiet", int'(data_clk), 0);
  endtask

  task automatic t_stream();
    // R9: the accepted write clears done at its own edge
    push_byte(8'h3C);
    chk("R9 done cleared", int'(tx_done), 0);
    push_byte(8'hC3);
    chk("R4 start stream", int'(tx_start), 1);
    step();
    exp_b[0] = 8'h3C;
    exp_b[1] = 8'hC3;
    run_bytes(2, 1, "stream R7");
  endtask

  task automatic t_capacity(input logic [1:0] sel);
    int cap;
    cap = (int'(sel) + 1) * 16;
    do_reset();
    cap_sel = sel;
    for (int i = 0; i <= cap; i++) begin
      push_byte(8'(i));
      exp_b[i] = 8'(i);
      if (i == cap - 1) chk("R2 not full below cap", int'(fifo_full), 0);
    end
    chk("R2 full at cap", int'(fifo_full), 1);
    chk("R3 no overflow yet", int'(overflow), 0);
    push_byte(8'hEE);
    chk("R3 overflow set", int'(overflow), 1);
    chk("R2 still full", int'(fifo_full), 1);
    if (sel != 2'b11) begin
      cap_sel = sel + 2'd1;
      #1;
      chk("R2 larger cap not full", int'(fifo_full), 0);
      cap_sel = sel;
      #1;
    end
    run_bytes(cap + 1, 0, "capacity R3");
    chk("R2 empty after drain", int'(fifo_empty), 1);
    chk("R3 overflow sticky", int'(overflow), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_stream();
    t_capacity(2'b00);
    t_capacity(2'b01);
    t_capacity(2'b10);
    t_capacity(2'b11);
    t_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule